// File: doc/BRIEF.md
# Folded Nibble Multiplier

This block is a sequential unsigned multiplier. It forms the product of two 8-bit operands using a single 4-bit by 4-bit multiplier that it reuses over four steps. A 2-bit step counter picks one pair of nibbles from the latched operands at each step. The nibble product goes into a product register. On the next cycle that register is shifted to its weight and added into a 16-bit accumulator, which drives the result port.

A client drives the operands and pulses `start` while `busy` is low. The block then runs for five cycles on its own. On the last of them it drops `busy` and pulses `done` for one cycle, and the full product appears on `prod`. The result stays on `prod` until the next accepted start. The nibble multiplier inside is a shift-and-add array. In that array, a row whose multiplier bit is zero adds nothing and passes its running sum straight through.

Top module: `folded_nibble_mult`

## Requirements
- R1: While rst_n is low at a clock edge, busy, done and prod are all cleared to zero at that edge. The reset is synchronous and active low.
- R2: When start is high and busy is low at an edge, op_a and op_b are captured at that edge. After the edge busy is 1 and prod is 0.
- R3: done goes high exactly five edges after the accepting edge. busy goes low at that same edge.
- R4: At done, prod equals op_a times op_b as unsigned 8-bit numbers captured at the accepting edge, with the full 16-bit result.
- R5: done is high for one cycle only.
- R6: While busy is high, the block ignores start and ignores any change on op_a or op_b.
- R7: While the block is idle, prod holds its last value until a start is accepted.
- R8: The steps run in a fixed order: step code 0 takes low(A)×low(B) with weight 1, 1 takes low(A)×high(B) with weight 16, 2 takes high(A)×low(B) with weight 16, and 3 takes high(A)×high(B) with weight 256. Each step's product lands in the accumulator one edge after it is formed. After the second, third and fourth edges past acceptance, prod therefore shows the running sums of steps 0, 0–1 and 0–2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a multiplication when idle |
| op_a | input | 8 | Multiplicand |
| op_b | input | 8 | Multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| prod | output | 16 | Accumulator, which holds the final product after done |

## Verification
The bench sweeps every value of op_a against a spread of op_b values, including 0 and 255. These cases catch a wrong shift weight on the top step and a lost carry out of the accumulator. At each intermediate cycle the bench compares prod with the expected running sum. A design that swapped the two cross terms or shifted one by the wrong amount would pass some final products but would fail those trace checks. During every operation the bench also inverts the operand inputs and pulses start again. A design that re-latched operands or restarted would give a wrong result or a late done. After each operation the bench checks that done has fallen and that prod has held, which exposes a stretched pulse or an accumulator that keeps counting.

// File: rtl/folded_nibble_mult.sv
module folded_nibble_mult #(
  parameter int NIB = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [2*NIB-1:0]   op_a,
  input  logic [2*NIB-1:0]   op_b,
  output logic               busy,
  output logic               done,
  output logic [4*NIB-1:0]   prod
);
  localparam int OPW = 2 * NIB;
  localparam int PW  = 2 * OPW;

  logic [OPW-1:0] a_q, b_q;
  logic [1:0]     step;
  logic           issuing;
  logic [PW-1:0]  pp;
  logic [1:0]     pp_tag;
  logic           pp_vld;
  logic [PW-1:0]  acc;

  logic [NIB-1:0] a_nib, b_nib;
  logic [OPW-1:0] row_sum;
  logic [PW-1:0]  weighted;

  assign a_nib = step[1] ? a_q[OPW-1:NIB] : a_q[NIB-1:0];
  assign b_nib = step[0] ? b_q[OPW-1:NIB] : b_q[NIB-1:0];

  always_comb begin
    row_sum = '0;
    for (int j = 0; j < NIB; j++)
      if (b_nib[j]) row_sum = row_sum + (OPW'(a_nib) << j);
  end

  always_comb begin
    case (pp_tag)
      2'd0:    weighted = pp;
      2'd3:    weighted = pp << OPW;
      default: weighted = pp << NIB;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q     <= '0;
      b_q     <= '0;
      step    <= '0;
      issuing <= 1'b0;
      pp      <= '0;
      pp_tag  <= '0;
      pp_vld  <= 1'b0;
      acc     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        a_q     <= op_a;
        b_q     <= op_b;
        acc     <= '0;
        step    <= '0;
        issuing <= 1'b1;
        pp_vld  <= 1'b0;
        busy    <= 1'b1;
      end else if (busy) begin
        if (issuing) begin
          pp      <= PW'(row_sum);
          pp_tag  <= step;
          pp_vld  <= 1'b1;
          step    <= step + 2'd1;
          if (step == 2'd3) issuing <= 1'b0;
        end else begin
          pp_vld <= 1'b0;
        end
        if (pp_vld) begin
          acc <= acc + weighted;
          if (pp_tag == 2'd3) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end

  assign prod = acc;
endmodule

module folded_nibble_mult_chk #(
  parameter int NIB = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [2*NIB-1:0] op_a,
  input logic [2*NIB-1:0] op_b,
  input logic             busy,
  input logic             done,
  input logic [4*NIB-1:0] prod
);
  logic [2*NIB-1:0] ca, cb;
  logic [2:0]       lat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ca  <= '0;
      cb  <= '0;
      lat <= '0;
    end else if (start && !busy) begin
      ca  <= op_a;
      cb  <= op_b;
      lat <= 3'd1;
    end else if (busy) begin
      lat <= lat + 3'd1;
    end
  end

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && prod == '0));
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && lat == 3'd6));
  a_r4_result: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (prod == (4*NIB)'(ca) * (4*NIB)'(cb)));
  a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(prod));
endmodule

bind folded_nibble_mult folded_nibble_mult_chk #(.NIB(NIB)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
  .busy(busy), .done(done), .prod(prod)
);

// File: tb/tb_folded_nibble_mult.sv
module tb_folded_nibble_mult;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  op_a = '0;
  logic [7:0]  op_b = '0;
  logic        busy, done;
  logic [15:0] prod;

  int checks = 0;
  int errors = 0;

  folded_nibble_mult dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .prod(prod)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] a, input logic [7:0] b, input bit trace);
    int ll, lh, hl, hh;
    ll = int'(a[3:0]) * int'(b[3:0]);
    lh = int'(a[3:0]) * int'(b[7:4]);
    hl = int'(a[7:4]) * int'(b[3:0]);
    hh = int'(a[7:4]) * int'(b[7:4]);
    @(negedge clk);
    op_a = a; op_b = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0; op_a = ~a; op_b = ~b;
    if (trace) begin
      chk(busy == 1'b1, "R2 busy", int'(busy), 1);
      chk(prod == 16'd0, "R2 prod cleared", int'(prod), 0);
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (trace) chk(prod == 16'(ll), "R8 step0", int'(prod), ll);
    @(negedge clk);
    if (trace) chk(prod == 16'(ll + (lh << 4)), "R8 step1", int'(prod), ll + (lh << 4));
    @(negedge clk);
    if (trace) begin
      chk(prod == 16'(ll + (lh << 4) + (hl << 4)), "R8 step2", int'(prod), ll + (lh << 4) + (hl << 4));
      chk(done == 1'b0, "R3 early done", int'(done), 0);
    end
    @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R3 done timing", int'({done, busy}), 2);
    chk(prod == 16'(int'(a) * int'(b)), "R4/R6 product", int'(prod), int'(a) * int'(b));
    @(negedge clk);
    chk(done == 1'b0, "R5 pulse width", int'(done), 0);
    chk(prod == 16'(int'(a) * int'(b)), "R7 hold", int'(prod), int'(a) * int'(b));
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && prod == 16'd0, "R1 reset", int'(prod), 0);
    rst_n = 1'b1;
    run_op(8'd255, 8'd255, 1'b1);
    run_op(8'd0, 8'd0, 1'b1);
    for (int a = 0; a < 256; a++) begin
      for (int k = 0; k < 37; k++) run_op(8'(a), 8'(k * 7), (k % 9) == 0);
      run_op(8'(a), 8'd255, 1'b1);
    end
    repeat (5) @(negedge clk);
    chk(prod == 16'(255 * 255) && busy == 1'b0, "R7 idle hold", int'(prod), 255 * 255);
    op_a = 8'd12; op_b = 8'd34;
    @(negedge clk);
    chk(prod == 16'(255 * 255), "R7 idle inputs ignored", int'(prod), 255 * 255);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && prod == 16'd0, "R1 reset again", int'(prod), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule